// File: doc/BRIEF.md
# Corrected-Error Counter Syndrome Register

This block is the 64-bit miscellaneous syndrome register of an error record. An error-report interface gives it a strobe for each corrected error and a syndrome tag with each strobe, such as the cache set and way that held the bad data. The register turns these reports into counts. Software reads the full 64-bit image on a plain read port. It can overwrite the counters on a plain write port, for example to clear them while an error keeps recurring.

Two parameters set the mode and the field width. In single mode, one counter counts every corrected error. In dual mode, the first countable error records its tag. After that, every error is sent to one of two counters: a "repeat" counter when its tag matches the recorded tag, and an "other" counter when it does not. Each counter has a sticky wrap flag. The `ovf_pending` output is high while any wrap flag is set. An interrupt controller outside this block can use it.

A cold reset clears all state. An error-recovery reset leaves the counts, flags and recorded tag unchanged. While the record-valid input is high, software cannot overwrite the recorded tag.

Top module: `cecnt_reg`

## Requirements
- R1: After cold reset (`rst_n` low), `rd_data` is all zero and `ovf_pending` is 0.
- R2: In single mode, each cycle with `err_valid` high and `recov_rst` low adds one to the counter, modulo 2^CW, whatever the tag is. The wide layout holds the counter in bits [46:32] and its wrap flag in bit 47. The narrow layout holds the counter in bits [38:32] and its wrap flag in bit 39.
- R3: A wrap flag goes to 1 when an increment takes its counter from all ones to zero. It stays at 1 through later increments until a software write changes it.
- R4: When the captured flag (bit 31) is 0, a countable error increments the repeat counter, sets the captured flag, and loads its tag into bits [SYN_W-1:0].
- R5: In dual mode, when the captured flag is 1, an error whose tag equals the recorded tag increments the repeat counter. Any other error increments the other counter. Each error increments exactly one counter.
- R6: The dual narrow layout is: repeat counter [38:32], repeat flag 39, other counter [46:40], other flag 47. The dual wide layout is: repeat counter [46:32], repeat flag 47, other counter [62:48], other flag 63.
- R7: While `recov_rst` is high, error reports are not counted or recorded. Counters, flags, the tag and the captured flag keep their values.
- R8: A write (`wr_en` high) loads the counter and flag fields from `wr_data`. If an error arrives in the same cycle, the written values take effect and the increment does not.
- R9: A write whose repeat-counter field is zero clears the captured flag, so the next countable error records a new tag. A write of all-zero counter and flag fields brings `ovf_pending` to 0.
- R10: While `rec_valid` is 1, writes leave the tag field unchanged. While `rec_valid` is 0, a write loads the tag field from `wr_data[SYN_W-1:0]`.
- R11: `ovf_pending` is 1 exactly when at least one wrap flag is 1.
- R12: Bits outside the tag, the captured flag, the counters and the flags read as zero and ignore writes. The captured flag itself ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, synchronous |
| recov_rst | input | 1 | Error-recovery reset; holds the record unchanged |
| err_valid | input | 1 | Corrected-error report strobe |
| err_syn | input | SYN_W | Syndrome tag of the reported error |
| rec_valid | input | 1 | Record holds a valid error; locks the tag field against writes |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write data |
| rd_data | output | 64 | Register image |
| ovf_pending | output | 1 | OR of all sticky wrap flags |

## Verification
Dual mode is tested by sending every one of the 16 tag values, several times over, after a tag has been recorded. This shows whether matching tags and non-matching tags each go to the correct counter.

Long runs of a single tag, and then of a different tag, drive each counter through its wrap. These runs check that each wrap sets only its own flag, and that the flag stays set.

Further patterns check the ordering rules:
- an error in the same cycle as a write, to show that the write wins;
- errors during recovery reset, to show that they are ignored;
- tag writes with `rec_valid` high and then low, to show the lock;
- an all-ones write, to separate reserved bits from live ones.

A wide single-mode instance is preloaded one step below its wrap. It then gets errors with differing tags, which checks the 15-bit field placement and that single mode counts every error regardless of its tag.

// File: rtl/cecnt_pkg.sv
package cecnt_pkg;

  localparam int REG_W   = 64;
  localparam int CAP_BIT = 31;
  localparam int REP_LSB = 32;

  // Counter width: wide layout 15 bits, narrow layout 7 bits
  function automatic int cnt_width(bit wide);
    return wide ? 15 : 7;
  endfunction

  function automatic int rep_of_pos(int cw);
    return REP_LSB + cw;
  endfunction

  function automatic int oth_lsb(int cw);
    return REP_LSB + cw + 1;
  endfunction

  function automatic int oth_of_pos(int cw);
    return REP_LSB + 2 * cw + 1;
  endfunction

endpackage

// File: rtl/cecnt_ctr.sv
module cecnt_ctr #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_cnt,
  input  logic          wr_of,
  output logic [CW-1:0] cnt,
  output logic          of_flag,
  output logic          wrap
);

  // increment that would roll the counter over from all ones
  assign wrap = inc & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      of_flag <= 1'b0;
    end else if (wr_en) begin
      cnt     <= wr_cnt;
      of_flag <= wr_of;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
      if (wrap) of_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/cecnt_steer.sv
module cecnt_steer #(
  parameter int SYN_W = 12,
  parameter bit DUAL  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [SYN_W-1:0] syn,
  input  logic             wr_en,
  input  logic [SYN_W-1:0] wr_tag,
  input  logic             wr_clr_cap,
  input  logic             rec_valid,
  output logic [SYN_W-1:0] tag,
  output logic             cap,
  output logic             inc_rep,
  output logic             inc_oth
);

  logic hit;

  assign hit = ~cap | (syn == tag);

  generate
    if (DUAL) begin : g_dual
      assign inc_rep = evt & hit;
      assign inc_oth = evt & ~hit;
    end else begin : g_single
      assign inc_rep = evt;
      assign inc_oth = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap <= 1'b0;
      tag <= '0;
    end else begin
      if (wr_en && wr_clr_cap) cap <= 1'b0;
      else if (evt)            cap <= 1'b1;

      if (wr_en && !rec_valid) tag <= wr_tag;
      else if (evt && !cap)    tag <= syn;
    end
  end

endmodule

// File: rtl/cecnt_reg.sv
module cecnt_reg #(
  parameter bit DUAL  = 1'b1,
  parameter bit WIDE  = 1'b1,
  parameter int SYN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recov_rst,
  input  logic             err_valid,
  input  logic [SYN_W-1:0] err_syn,
  input  logic             rec_valid,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  output logic [63:0]      rd_data,
  output logic             ovf_pending
);

  import cecnt_pkg::*;

  localparam int CW      = cnt_width(WIDE);
  localparam int REP_OF  = rep_of_pos(CW);
  localparam int OTH_LSB = oth_lsb(CW);
  localparam int OTH_OF  = oth_of_pos(CW);

  logic             evt;
  logic             inc_rep, inc_oth;
  logic             wrap_a, wrap_b;
  logic [CW-1:0]    cnt_a, cnt_b;
  logic             of_a, of_b;
  logic [SYN_W-1:0] tag;
  logic             cap;
  logic [CW-1:0]    wr_cnt_a;
  logic             wr_of_a;
  logic             wr_clr_cap;

  assign evt        = err_valid & ~recov_rst;
  assign wr_cnt_a   = wr_data[REP_LSB +: CW];
  assign wr_of_a    = wr_data[REP_OF];
  assign wr_clr_cap = (wr_cnt_a == '0);

  cecnt_steer #(.SYN_W(SYN_W), .DUAL(DUAL)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .syn        (err_syn),
    .wr_en      (wr_en),
    .wr_tag     (wr_data[SYN_W-1:0]),
    .wr_clr_cap (wr_clr_cap),
    .rec_valid  (rec_valid),
    .tag        (tag),
    .cap        (cap),
    .inc_rep    (inc_rep),
    .inc_oth    (inc_oth)
  );

  cecnt_ctr #(.CW(CW)) u_rep (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc_rep),
    .wr_en   (wr_en),
    .wr_cnt  (wr_cnt_a),
    .wr_of   (wr_of_a),
    .cnt     (cnt_a),
    .of_flag (of_a),
    .wrap    (wrap_a)
  );

  generate
    if (DUAL) begin : g_oth
      cecnt_ctr #(.CW(CW)) u_oth (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc_oth),
        .wr_en   (wr_en),
        .wr_cnt  (wr_data[OTH_LSB +: CW]),
        .wr_of   (wr_data[OTH_OF]),
        .cnt     (cnt_b),
        .of_flag (of_b),
        .wrap    (wrap_b)
      );
    end else begin : g_no_oth
      assign cnt_b  = '0;
      assign of_b   = 1'b0;
      assign wrap_b = inc_oth;
    end
  endgenerate

  always_comb begin
    rd_data                 = '0;
    rd_data[SYN_W-1:0]      = tag;
    rd_data[CAP_BIT]        = cap;
    rd_data[REP_LSB +: CW]  = cnt_a;
    rd_data[REP_OF]         = of_a;
    if (DUAL) begin
      rd_data[OTH_LSB +: CW] = cnt_b;
      rd_data[OTH_OF]        = of_b;
    end
  end

  assign ovf_pending = of_a | of_b;

endmodule

// File: rtl/cecnt_chk.sv
module cecnt_chk #(
  parameter int CW    = 7,
  parameter int SYN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             recov_rst,
  input logic             wr_en,
  input logic             rec_valid,
  input logic             evt,
  input logic             inc_rep,
  input logic             inc_oth,
  input logic             wrap_a,
  input logic [CW-1:0]    cnt_a,
  input logic             of_a,
  input logic [SYN_W-1:0] tag,
  input logic             cap,
  input logic [CW-1:0]    wr_cnt_a,
  input logic             wr_of_a,
  input logic             ovf_pending
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (rst_n || (!ovf_pending && !cap && cnt_a == '0)));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_rep && !wr_en) |=> cnt_a == CW'($past(cnt_a) + 1'b1));

  p_wrap_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_a && !wr_en) |=> of_a);

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (of_a && !wr_en) |=> of_a);

  p_first_rep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !cap) |-> inc_rep);

  p_one_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_rep, inc_oth}));

  p_recov_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (recov_rst && !wr_en) |=> ($stable(cnt_a) && $stable(of_a) && $stable(tag) && $stable(cap)));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_a == $past(wr_cnt_a) && of_a == $past(wr_of_a)));

  p_clear_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cnt_a == '0) |=> !cap);

  p_tag_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rec_valid && cap) |=> $stable(tag));

endmodule

bind cecnt_reg cecnt_chk #(.CW(CW), .SYN_W(SYN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .recov_rst   (recov_rst),
  .wr_en       (wr_en),
  .rec_valid   (rec_valid),
  .evt         (evt),
  .inc_rep     (inc_rep),
  .inc_oth     (inc_oth),
  .wrap_a      (wrap_a),
  .cnt_a       (cnt_a),
  .of_a        (of_a),
  .tag         (tag),
  .cap         (cap),
  .wr_cnt_a    (wr_cnt_a),
  .wr_of_a     (wr_of_a),
  .ovf_pending (ovf_pending)
);

// File: tb/cecnt_reg_tb.sv
module cecnt_reg_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        recov_rst, err_valid, rec_valid, wr_en;
  logic [3:0]  err_syn;
  logic [63:0] wr_data, rd_data;
  logic        ovf_pending;

  logic        s_err_valid, s_wr_en;
  logic [3:0]  s_err_syn;
  logic [63:0] s_wr_data, s_rd_data;
  logic        s_ovf;

  cecnt_reg #(.DUAL(1'b1), .WIDE(1'b0), .SYN_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .recov_rst(recov_rst), .err_valid(err_valid),
    .err_syn(err_syn), .rec_valid(rec_valid), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ovf_pending(ovf_pending)
  );

  cecnt_reg #(.DUAL(1'b0), .WIDE(1'b1), .SYN_W(4)) sgl_i (
    .clk(clk), .rst_n(rst_n), .recov_rst(1'b0), .err_valid(s_err_valid),
    .err_syn(s_err_syn), .rec_valid(1'b0), .wr_en(s_wr_en), .wr_data(s_wr_data),
    .rd_data(s_rd_data), .ovf_pending(s_ovf)
  );

  int nchk = 0;
  int nerr = 0;

  // reference state of the dual narrow instance
  int m_rep = 0, m_oth = 0, m_tag = 0;
  bit m_ofr = 0, m_ofo = 0, m_cap = 0;

  function automatic logic [63:0] exp_rd();
    logic [63:0] r;
    r = 64'(m_tag & 15)
      + (64'(m_cap) << 31)
      + (64'(m_rep & 127) << 32)
      + (64'(m_ofr) << 39)
      + (64'(m_oth & 127) << 40)
      + (64'(m_ofo) << 47);
    return r;
  endfunction

  function automatic logic [63:0] mk_wd(int rep, bit ofr, int oth, bit ofo, int tg);
    return 64'(tg & 15) + (64'(rep & 127) << 32) + (64'(ofr) << 39)
         + (64'(oth & 127) << 40) + (64'(ofo) << 47);
  endfunction

  task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(bit ev, int syn, bit we, logic [63:0] wd, bit rv, bit rr, string req);
    bit e, hit, nc;
    int nt;
    err_valid = ev; err_syn = 4'(syn); wr_en = we; wr_data = wd;
    rec_valid = rv; recov_rst = rr;
    @(posedge clk);
    #1;
    err_valid = 0; wr_en = 0; rec_valid = 0; recov_rst = 0;
    e   = ev && !rr;
    hit = !m_cap || ((syn & 15) == m_tag);
    nt  = m_tag;
    if (e && !m_cap) nt = syn & 15;
    if (we && !rv)   nt = int'(wd[3:0]);
    nc = m_cap;
    if (e) nc = 1;
    if (we && wd[38:32] == 7'd0) nc = 0;
    if (we) begin
      m_rep = int'(wd[38:32]); m_ofr = wd[39];
      m_oth = int'(wd[46:40]); m_ofo = wd[47];
    end else if (e) begin
      if (hit) begin
        if (m_rep == 127) begin m_rep = 0; m_ofr = 1; end else m_rep++;
      end else begin
        if (m_oth == 127) begin m_oth = 0; m_ofo = 1; end else m_oth++;
      end
    end
    m_tag = nt; m_cap = nc;
    chk64(req, rd_data, exp_rd());
    chk1({req, "/R11"}, ovf_pending, m_ofr | m_ofo);
  endtask

  task automatic scyc(bit ev, int syn, bit we, logic [63:0] wd);
    s_err_valid = ev; s_err_syn = 4'(syn); s_wr_en = we; s_wr_data = wd;
    @(posedge clk);
    #1;
    s_err_valid = 0; s_wr_en = 0;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 0; recov_rst = 0; err_valid = 0; err_syn = 0; rec_valid = 0;
    wr_en = 0; wr_data = 0;
    s_err_valid = 0; s_err_syn = 0; s_wr_en = 0; s_wr_data = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;

    // R1 reset state
    chk64("R1", rd_data, 64'h0);
    chk1("R1", ovf_pending, 1'b0);
    chk64("R1", s_rd_data, 64'h0);

    // R4 first error records its tag
    cyc(1, 5, 0, 0, 0, 0, "R4");

    // R5 sweep every tag several times
    for (int rnd = 0; rnd < 3; rnd++)
      for (int s = 0; s < 16; s++)
        cyc(1, s, 0, 0, 0, 0, "R5");

    // R3 repeat counter wraps and flag stays set
    for (int i = 0; i < 130; i++) cyc(1, 5, 0, 0, 0, 0, "R3");
    chk1("R3", rd_data[39], 1'b1);

    // R3 other counter wraps
    for (int i = 0; i < 130; i++) cyc(1, 6, 0, 0, 0, 0, "R3");
    chk1("R3", rd_data[47], 1'b1);

    // R6 field placement via write pattern
    cyc(0, 0, 1, mk_wd(8'h55, 0, 8'h2A, 1, 5), 0, 0, "R6");
    chk64("R6", rd_data, 64'h0000_AA55_8000_0005);

    // R8 write wins over same-cycle increment
    cyc(1, 5, 1, mk_wd(3, 0, 9, 0, 5), 0, 0, "R8");
    cyc(1, 7, 1, mk_wd(20, 1, 30, 0, 5), 0, 0, "R8");

    // R9 write of zero gives a quiescent record, next error recaptures
    cyc(0, 0, 1, 64'h0, 0, 0, "R9");
    chk1("R9", ovf_pending, 1'b0);
    cyc(1, 9, 0, 0, 0, 0, "R9");
    cyc(1, 9, 0, 0, 0, 0, "R9");
    cyc(1, 4, 0, 0, 0, 0, "R9");

    // R10 tag write locked while record valid
    cyc(0, 0, 1, mk_wd(m_rep, 0, m_oth, 0, 3), 1, 0, "R10");
    chk64("R10", rd_data[3:0], 64'h9);
    cyc(0, 0, 1, mk_wd(m_rep, 0, m_oth, 0, 3), 0, 0, "R10");
    chk64("R10", rd_data[3:0], 64'h3);

    // R7 recovery reset holds the record
    for (int s = 0; s < 4; s++) cyc(1, s, 0, 0, 0, 1, "R7");

    // R12 reserved bits and captured flag ignore writes
    cyc(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R12");
    chk64("R12", rd_data & 64'hFFFF_0000_7FFF_FFF0, 64'h0);

    // R11 single flag drives pending
    cyc(0, 0, 1, mk_wd(1, 0, 0, 1, 0), 0, 0, "R11");
    chk1("R11", ovf_pending, 1'b1);
    cyc(0, 0, 1, mk_wd(1, 1, 0, 0, 0), 0, 0, "R11");
    chk1("R11", ovf_pending, 1'b1);

    // R2 single wide: every tag counts, wrap at 15 bits
    scyc(0, 0, 1, 64'h0000_7FFE_0000_0000);
    scyc(1, 1, 0, 0);
    chk64("R2", s_rd_data, 64'h0000_7FFF_8000_0001);
    chk1("R2", s_ovf, 1'b0);
    scyc(1, 2, 0, 0);
    chk64("R2", s_rd_data, 64'h0000_8000_8000_0001);
    chk1("R2", s_ovf, 1'b1);
    scyc(1, 3, 0, 0);
    chk64("R2", s_rd_data, 64'h0000_8001_8000_0001);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule